// File: doc/BRIEF.md
# Engine Channel Activation Controller

This block is the control and status front end of a single data-engine channel. Software programs it through a small word-addressed write port. It holds the channel configuration (burst limits and an access-protection bit), a separately written operation-mode selector, and the chain pointer to the first descriptor. An activation register accepts start, stop, pause and restart commands. The controller checks each command against the current channel state and, for start, checks the chain pointer against the alignment the selected mode needs.

Legal commands move the channel between idle, active and paused. Each legal command also emits a one-cycle strobe to the datapath: start, abort, pause or resume. The datapath reports completion with a done pulse, which returns an active channel to idle. Refused operations leave the state untouched and set sticky flags that software reads back and clears by writing ones.

Register map (word address on `wr_addr_i` and `rd_addr_i`):

- Address 0 is the configuration register. Bits [2:0] read back the mode, bits [6:4] hold the source burst limit, bits [10:8] hold the destination burst limit, and bit 12 is protection.
- Address 1 is the mode register. Bits [2:0] hold the mode: 0 XOR, 1 CRC, 2 copy.
- Address 2 is the chain pointer.
- Address 3 is the activation register. Bits [3:0] are commands (bit 0 start, bit 1 stop, bit 2 pause, bit 3 restart). Bits [5:4] are status. Bit 8 is done, bit 9 is error and bit 10 is busy; writing 1 to any of these three bits clears it.

Top module: `chan_act_ctrl`

## Requirements
- R1: After reset the configuration register reads 0x1440 (source and destination burst 4, protection set, mode 0), and the activation, mode and pointer registers read 0.
- R2: A write to address 0 updates only the burst and protection fields; the mode field keeps its value whatever the written bits [2:0] hold.
- R3: Status is encoded 00 idle, 01 active, 10 paused; the value 11 never appears.
- R4: Start from idle or paused with a valid pointer makes the channel active and gives exactly one start strobe.
- R5: Start while active leaves the state unchanged, gives no strobe and sets the busy flag (bit 10).
- R6: Pause moves active to paused with one pause strobe; restart moves paused to active with one resume strobe.
- R7: Stop while active returns the channel to idle with one abort strobe; stop while idle changes nothing and sets no flag.
- R8: Pause outside active, restart outside paused, stop while paused, and any command word with more than one command bit set all set the error flag (bit 9), give no strobe and keep the state.
- R9: Start is refused with the error flag when the pointer is zero, when the mode is XOR and pointer bits [5:0] are not all clear, when the mode is CRC or copy and bits [4:0] are not all clear, or when the mode value is 3 to 7.
- R10: A done pulse while active returns the channel to idle and sets the done flag (bit 8). A done pulse in any other state has no effect. A command evaluated in the same cycle as a done pulse is checked against the idle state.
- R11: Command bits read back as written in the cycle after the write and then clear by themselves. The status change and the strobe appear one cycle after the write.
- R12: Writes to the mode or pointer register while the channel is not idle are dropped and set the error flag.
- R13: Writing 1 to bit 8, 9 or 10 of the activation register clears that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| done_i | input | 1 | Completion pulse from the datapath |
| start_o | output | 1 | Start strobe to the datapath |
| abort_o | output | 1 | Abort strobe to the datapath |
| pause_o | output | 1 | Pause strobe to the datapath |
| resume_o | output | 1 | Resume strobe to the datapath |
| status_o | output | 2 | Channel state |
| mode_o | output | 3 | Selected operation mode |
| desc_ptr_o | output | 32 | Chain pointer |
| src_burst_o | output | 3 | Source burst limit |
| dst_burst_o | output | 3 | Destination burst limit |
| protect_o | output | 1 | Access-protection bit |

## Verification
The hardest situation to reach from the ports is a command evaluated in the same cycle that the datapath reports completion. The command sits in the pending stage for one cycle, so the bench writes a pause while the channel is active and raises done exactly one cycle later. Both then land on the evaluation edge. The expected result is idle with the done flag set, an error for the pause, and no pause strobe. Legal paths are scored by comparing every observed strobe against a queue of expected strobes, so a spurious or missing strobe from any refused command is caught.

// File: rtl/chan_act_pkg.sv
package chan_act_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'b00,
      ST_ACTIVE = 2'b01,
      ST_PAUSED = 2'b10,
      ST_UNDEF  = 2'b11
   } chan_state_e;

   localparam logic [2:0] MODE_XOR  = 3'd0;
   localparam logic [2:0] MODE_CRC  = 3'd1;
   localparam logic [2:0] MODE_COPY = 3'd2;

   localparam logic [1:0] ADDR_CFG  = 2'd0;
   localparam logic [1:0] ADDR_MODE = 2'd1;
   localparam logic [1:0] ADDR_PTR  = 2'd2;
   localparam logic [1:0] ADDR_ACT  = 2'd3;

   localparam int CMD_W       = 4;
   localparam int CMD_START   = 0;
   localparam int CMD_STOP    = 1;
   localparam int CMD_PAUSE   = 2;
   localparam int CMD_RESTART = 3;

   localparam int ACT_ST_LSB  = 4;
   localparam int FLAG_DONE   = 8;
   localparam int FLAG_ERR    = 9;
   localparam int FLAG_BUSY   = 10;

   localparam int CFG_SRC_LSB = 4;
   localparam int CFG_DST_LSB = 8;
   localparam int CFG_PROT    = 12;

endpackage

// File: rtl/chan_desc_check.sv
module chan_desc_check
   import chan_act_pkg::*;
#(
   parameter int PTR_W      = 32,
   parameter int XOR_ALIGN  = 6,
   parameter int BASE_ALIGN = 5
) (
   input  logic [2:0]       mode_i,
   input  logic [PTR_W-1:0] ptr_i,
   output logic             ptr_ok_o
);

   generate
      if (XOR_ALIGN < 1 || XOR_ALIGN >= PTR_W)
         $error("chan_desc_check: XOR_ALIGN out of range");
      if (BASE_ALIGN < 1 || BASE_ALIGN >= PTR_W)
         $error("chan_desc_check: BASE_ALIGN out of range");
   endgenerate

   localparam logic [PTR_W-1:0] XOR_MASK  =
      {{(PTR_W-XOR_ALIGN){1'b0}}, {XOR_ALIGN{1'b1}}};
   localparam logic [PTR_W-1:0] BASE_MASK =
      {{(PTR_W-BASE_ALIGN){1'b0}}, {BASE_ALIGN{1'b1}}};

   logic aligned;

   always_comb begin
      case (mode_i)
         MODE_XOR:            aligned = ((ptr_i & XOR_MASK) == '0);
         MODE_CRC, MODE_COPY: aligned = ((ptr_i & BASE_MASK) == '0);
         default:             aligned = 1'b0;
      endcase
      ptr_ok_o = aligned && (ptr_i != '0);
   end

   always_comb begin
      if (ptr_i == '0)
         assert (!ptr_ok_o) else $error("p_zero_ptr_r9 violated");
   end

endmodule

// File: rtl/chan_cfg_regs.sv
module chan_cfg_regs
   import chan_act_pkg::*;
#(
   parameter int              DATA_W  = 32,
   parameter int              PTR_W   = 32,
   parameter int              BURST_W = 3,
   parameter logic [BURST_W-1:0] RST_SRC = 3'd4,
   parameter logic [BURST_W-1:0] RST_DST = 3'd4,
   parameter logic            RST_PROT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic [1:0]         wr_addr_i,
   input  logic [DATA_W-1:0]  wr_data_i,
   input  logic               idle_i,
   output logic [2:0]         mode_o,
   output logic [PTR_W-1:0]   ptr_o,
   output logic [BURST_W-1:0] src_burst_o,
   output logic [BURST_W-1:0] dst_burst_o,
   output logic               prot_o,
   output logic               refuse_o
);

   generate
      if (PTR_W > DATA_W)
         $error("chan_cfg_regs: pointer wider than data bus");
      if (BURST_W < 1 || BURST_W > 4)
         $error("chan_cfg_regs: BURST_W must be 1 to 4");
   endgenerate

   logic cfg_we, mode_we, ptr_we;

   assign cfg_we   = wr_en_i && (wr_addr_i == ADDR_CFG);
   assign mode_we  = wr_en_i && (wr_addr_i == ADDR_MODE) && idle_i;
   assign ptr_we   = wr_en_i && (wr_addr_i == ADDR_PTR)  && idle_i;
   assign refuse_o = wr_en_i && !idle_i &&
                     ((wr_addr_i == ADDR_MODE) || (wr_addr_i == ADDR_PTR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_burst_o <= RST_SRC;
         dst_burst_o <= RST_DST;
         prot_o      <= RST_PROT;
      end else if (cfg_we) begin
         src_burst_o <= wr_data_i[CFG_SRC_LSB +: BURST_W];
         dst_burst_o <= wr_data_i[CFG_DST_LSB +: BURST_W];
         prot_o      <= wr_data_i[CFG_PROT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_o <= MODE_XOR;
      else if (mode_we) mode_o <= wr_data_i[2:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_o <= '0;
      else if (ptr_we) ptr_o <= wr_data_i[PTR_W-1:0];
   end

   p_cfg_keeps_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_addr_i == ADDR_CFG) |=> $stable(mode_o));

   p_mode_held_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !idle_i |=> $stable(mode_o));

   p_ptr_held_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !idle_i |=> $stable(ptr_o));

endmodule

// File: rtl/chan_cmd_fsm.sv
module chan_cmd_fsm
   import chan_act_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr_i,
   input  logic [CMD_W-1:0] cmd_i,
   input  logic [2:0]       clr_i,
   input  logic             ptr_ok_i,
   input  logic             done_i,
   input  logic             refuse_i,
   output chan_state_e      state_o,
   output logic [CMD_W-1:0] pend_o,
   output logic             start_o,
   output logic             abort_o,
   output logic             pause_o,
   output logic             resume_o,
   output logic             done_flag_o,
   output logic             err_flag_o,
   output logic             busy_flag_o
);

   chan_state_e eff_state, nxt_state;
   logic        done_hit;
   logic        s_start, s_abort, s_pause, s_resume;
   logic        set_err, set_busy;

   assign done_hit  = done_i && (state_o == ST_ACTIVE);
   assign eff_state = done_hit ? ST_IDLE : state_o;

   always_comb begin
      nxt_state = eff_state;
      s_start   = 1'b0;
      s_abort   = 1'b0;
      s_pause   = 1'b0;
      s_resume  = 1'b0;
      set_err   = 1'b0;
      set_busy  = 1'b0;
      if (pend_o != '0) begin
         if (!$onehot(pend_o)) begin
            set_err = 1'b1;
         end else if (pend_o[CMD_START]) begin
            if (eff_state == ST_ACTIVE) set_busy = 1'b1;
            else if (ptr_ok_i) begin
               nxt_state = ST_ACTIVE;
               s_start   = 1'b1;
            end else set_err = 1'b1;
         end else if (pend_o[CMD_STOP]) begin
            if (eff_state == ST_ACTIVE) begin
               nxt_state = ST_IDLE;
               s_abort   = 1'b1;
            end else if (eff_state == ST_PAUSED) set_err = 1'b1;
         end else if (pend_o[CMD_PAUSE]) begin
            if (eff_state == ST_ACTIVE) begin
               nxt_state = ST_PAUSED;
               s_pause   = 1'b1;
            end else set_err = 1'b1;
         end else begin
            if (eff_state == ST_PAUSED) begin
               nxt_state = ST_ACTIVE;
               s_resume  = 1'b1;
            end else set_err = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_o  <= ST_IDLE;
         pend_o   <= '0;
         start_o  <= 1'b0;
         abort_o  <= 1'b0;
         pause_o  <= 1'b0;
         resume_o <= 1'b0;
      end else begin
         state_o  <= nxt_state;
         pend_o   <= cmd_wr_i ? cmd_i : '0;
         start_o  <= s_start;
         abort_o  <= s_abort;
         pause_o  <= s_pause;
         resume_o <= s_resume;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_flag_o <= 1'b0;
         err_flag_o  <= 1'b0;
         busy_flag_o <= 1'b0;
      end else begin
         done_flag_o <= (done_flag_o & ~clr_i[0]) | done_hit;
         err_flag_o  <= (err_flag_o  & ~clr_i[1]) | set_err | refuse_i;
         busy_flag_o <= (busy_flag_o & ~clr_i[2]) | set_busy;
      end
   end

   p_status_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      state_o != ST_UNDEF);

   p_strobe_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_o, abort_o, pause_o, resume_o}));

   p_start_needs_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o[CMD_START] && !ptr_ok_i) |=> !start_o);

   p_busy_no_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o == 4'b0001 && state_o == ST_ACTIVE && !done_i) |=>
      (state_o == ST_ACTIVE && busy_flag_o && !start_o));

   p_cmd_selfclear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o != '0 && !cmd_wr_i) |=> pend_o == '0);

   p_done_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && state_o == ST_ACTIVE && pend_o == '0) |=>
      (state_o == ST_IDLE && done_flag_o));

   p_resume_from_pause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o == 4'b1000 && state_o != ST_PAUSED) |=> !resume_o);

endmodule

// File: rtl/chan_act_ctrl.sv
module chan_act_ctrl
   import chan_act_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int PTR_W      = 32,
   parameter int BURST_W    = 3,
   parameter int XOR_ALIGN  = 6,
   parameter int BASE_ALIGN = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic [1:0]         wr_addr_i,
   input  logic [DATA_W-1:0]  wr_data_i,
   input  logic [1:0]         rd_addr_i,
   output logic [DATA_W-1:0]  rd_data_o,
   input  logic               done_i,
   output logic               start_o,
   output logic               abort_o,
   output logic               pause_o,
   output logic               resume_o,
   output logic [1:0]         status_o,
   output logic [2:0]         mode_o,
   output logic [PTR_W-1:0]   desc_ptr_o,
   output logic [BURST_W-1:0] src_burst_o,
   output logic [BURST_W-1:0] dst_burst_o,
   output logic               protect_o
);

   generate
      if (DATA_W < FLAG_BUSY + 3)
         $error("chan_act_ctrl: data bus too narrow for register fields");
   endgenerate

   chan_state_e      state;
   logic [CMD_W-1:0] pend;
   logic             ptr_ok, refuse;
   logic             f_done, f_err, f_busy;
   logic             cmd_wr;

   assign cmd_wr = wr_en_i && (wr_addr_i == ADDR_ACT);

   chan_cfg_regs #(
      .DATA_W(DATA_W), .PTR_W(PTR_W), .BURST_W(BURST_W),
      .RST_SRC(BURST_W'(4)), .RST_DST(BURST_W'(4)), .RST_PROT(1'b1)
   ) cfg_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .idle_i(state == ST_IDLE),
      .mode_o(mode_o), .ptr_o(desc_ptr_o),
      .src_burst_o(src_burst_o), .dst_burst_o(dst_burst_o),
      .prot_o(protect_o), .refuse_o(refuse)
   );

   chan_desc_check #(
      .PTR_W(PTR_W), .XOR_ALIGN(XOR_ALIGN), .BASE_ALIGN(BASE_ALIGN)
   ) chk_i (
      .mode_i(mode_o), .ptr_i(desc_ptr_o), .ptr_ok_o(ptr_ok)
   );

   chan_cmd_fsm fsm_i (
      .clk(clk), .rst_n(rst_n),
      .cmd_wr_i(cmd_wr), .cmd_i(wr_data_i[CMD_W-1:0]),
      .clr_i(cmd_wr ? wr_data_i[FLAG_BUSY:FLAG_DONE] : 3'b000),
      .ptr_ok_i(ptr_ok), .done_i(done_i), .refuse_i(refuse),
      .state_o(state), .pend_o(pend),
      .start_o(start_o), .abort_o(abort_o),
      .pause_o(pause_o), .resume_o(resume_o),
      .done_flag_o(f_done), .err_flag_o(f_err), .busy_flag_o(f_busy)
   );

   assign status_o = state;

   always_comb begin
      rd_data_o = '0;
      case (rd_addr_i)
         ADDR_CFG: begin
            rd_data_o[2:0]                      = mode_o;
            rd_data_o[CFG_SRC_LSB +: BURST_W]   = src_burst_o;
            rd_data_o[CFG_DST_LSB +: BURST_W]   = dst_burst_o;
            rd_data_o[CFG_PROT]                 = protect_o;
         end
         ADDR_MODE: rd_data_o[2:0] = mode_o;
         ADDR_PTR:  rd_data_o[PTR_W-1:0] = desc_ptr_o;
         default: begin
            rd_data_o[CMD_W-1:0]          = pend;
            rd_data_o[ACT_ST_LSB +: 2]    = state;
            rd_data_o[FLAG_DONE]          = f_done;
            rd_data_o[FLAG_ERR]           = f_err;
            rd_data_o[FLAG_BUSY]          = f_busy;
         end
      endcase
   end

   p_abort_from_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> ($past(status_o) == 2'b01 && status_o == 2'b00));

   p_pause_from_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pause_o |-> ($past(status_o) == 2'b01 && status_o == 2'b10));

endmodule

// File: tb/chan_act_ctrl_tb_top.sv
`timescale 1ns/1ps
module chan_act_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        done = 1'b0;
   logic        start_s, abort_s, pause_s, resume_s;
   logic [1:0]  status;
   logic [2:0]  mode;
   logic [31:0] dptr;
   logic [2:0]  sb, db;
   logic        prot;

   int n_tests = 0;
   int n_fail  = 0;
   logic [3:0] exp_q[$];

   localparam logic [3:0] S_START  = 4'b0001;
   localparam logic [3:0] S_ABORT  = 4'b0010;
   localparam logic [3:0] S_PAUSE  = 4'b0100;
   localparam logic [3:0] S_RESUME = 4'b1000;

   always #4 clk = ~clk;

   chan_act_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data), .done_i(done),
      .start_o(start_s), .abort_o(abort_s), .pause_o(pause_s),
      .resume_o(resume_s), .status_o(status), .mode_o(mode),
      .desc_ptr_o(dptr), .src_burst_o(sb), .dst_burst_o(db),
      .protect_o(prot)
   );

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // monitor: every strobe must match the front of the expected queue
   always @(negedge clk) begin
      logic [3:0] seen;
      seen = {resume_s, pause_s, abort_s, start_s};
      if (rst_n && seen != 4'b0) begin
         if (exp_q.size() == 0) check("R8 unexpected strobe", {28'b0, seen}, 32'h0);
         else check("R4/R6/R7 strobe", {28'b0, seen}, {28'b0, exp_q.pop_front()});
      end
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic cmd(input logic [3:0] c);
      wr(2'd3, {28'b0, c});
      @(negedge clk);
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic clr_flags();
      wr(2'd3, 32'h700);
   endtask

   task automatic pulse_done();
      @(negedge clk);
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      rd(2'd0, v); check("R1 cfg reset", v, 32'h1440);
      rd(2'd3, v); check("R1 act reset", v, 32'h0);
      rd(2'd2, v); check("R1 ptr reset", v, 32'h0);
      rd(2'd1, v); check("R1 mode reset", v, 32'h0);

      // R2 cfg write leaves mode alone
      wr(2'd0, 32'h0000_0237);
      rd(2'd0, v); check("R2 cfg fields", v, 32'h230);
      check("R2 mode kept", {29'b0, mode}, 32'h0);

      // R7 stop while idle: no-op
      cmd(4'b0010);
      rd(2'd3, v); check("R7 stop idle", v, 32'h0);

      // R9 zero pointer rejected
      cmd(4'b0001);
      rd(2'd3, v); check("R9 zero ptr", v, 32'h200);
      clr_flags();
      rd(2'd3, v); check("R13 clear err", v, 32'h0);

      // R9 XOR alignment needs bits [5:0] clear
      wr(2'd2, 32'h1020);
      cmd(4'b0001);
      rd(2'd3, v); check("R9 xor misaligned", v, 32'h200);
      clr_flags();

      // R4 good start
      wr(2'd2, 32'h1040);
      exp_q.push_back(S_START);
      cmd(4'b0001);
      rd(2'd3, v); check("R4 start active", v, 32'h010);
      check("R4 ptr out", dptr, 32'h1040);

      // R5 start while active
      cmd(4'b0001);
      rd(2'd3, v); check("R5 busy", v, 32'h410);
      clr_flags();
      rd(2'd3, v); check("R13 clear busy", v, 32'h010);

      // R12 writes while active refused
      wr(2'd2, 32'h2000);
      rd(2'd2, v); check("R12 ptr kept", v, 32'h1040);
      wr(2'd1, 32'h1);
      rd(2'd1, v); check("R12 mode kept", v, 32'h0);
      rd(2'd3, v); check("R12 err flag", v, 32'h210);
      clr_flags();

      // R6 pause / restart, R8 pause while paused
      exp_q.push_back(S_PAUSE);
      cmd(4'b0100);
      rd(2'd3, v); check("R6 paused", v, 32'h020);
      cmd(4'b0100);
      rd(2'd3, v); check("R8 pause paused", v, 32'h220);
      clr_flags();
      exp_q.push_back(S_RESUME);
      cmd(4'b1000);
      rd(2'd3, v); check("R6 resumed", v, 32'h010);

      // R10 done returns to idle; done while idle ignored
      pulse_done();
      rd(2'd3, v); check("R10 done idle", v, 32'h100);
      clr_flags();
      pulse_done();
      rd(2'd3, v); check("R10 done ignored idle", v, 32'h0);

      // R9 CRC needs only bits [4:0] clear
      wr(2'd1, 32'h1);
      wr(2'd2, 32'h1020);
      exp_q.push_back(S_START);
      cmd(4'b0001);
      rd(2'd3, v); check("R9 crc aligned start", v, 32'h010);
      exp_q.push_back(S_ABORT);
      cmd(4'b0010);
      rd(2'd3, v); check("R7 stop active", v, 32'h000);

      // R8 restart / pause from idle
      cmd(4'b1000);
      rd(2'd3, v); check("R8 restart idle", v, 32'h200);
      clr_flags();
      cmd(4'b0100);
      rd(2'd3, v); check("R8 pause idle", v, 32'h200);
      clr_flags();

      // R8 stop while paused, R4 start from paused
      exp_q.push_back(S_START);
      cmd(4'b0001);
      exp_q.push_back(S_PAUSE);
      cmd(4'b0100);
      cmd(4'b0010);
      rd(2'd3, v); check("R8 stop paused", v, 32'h220);
      clr_flags();
      exp_q.push_back(S_START);
      cmd(4'b0001);
      rd(2'd3, v); check("R4 start from paused", v, 32'h010);

      // R10 done in same cycle as pause evaluation
      wr(2'd3, 32'h4);
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      rd(2'd3, v); check("R10 done beats pause", v, 32'h300);
      clr_flags();

      // R8 multi-bit command
      cmd(4'b0011);
      rd(2'd3, v); check("R8 multi-bit", v, 32'h200);
      clr_flags();

      // R9 undefined mode rejected
      wr(2'd1, 32'h3);
      wr(2'd2, 32'h1040);
      cmd(4'b0001);
      rd(2'd3, v); check("R9 bad mode", v, 32'h200);
      clr_flags();

      // R9 copy mode accepts 32-byte aligned pointer
      wr(2'd1, 32'h2);
      wr(2'd2, 32'h1060);
      exp_q.push_back(S_START);
      cmd(4'b0001);
      rd(2'd3, v); check("R9 copy start", v, 32'h010);
      check("R9 mode out", {29'b0, mode}, 32'h2);

      // R11 command bits visible one cycle then cleared
      exp_q.push_back(S_PAUSE);
      wr(2'd3, 32'h4);
      rd(2'd3, v); check("R11 pending visible", v, 32'h014);
      @(negedge clk);
      rd(2'd3, v); check("R11 self-cleared", v, 32'h020);
      check("R3 status paused", {30'b0, status}, 32'h2);
      exp_q.push_back(S_RESUME);
      cmd(4'b1000);
      pulse_done();
      clr_flags();
      rd(2'd3, v); check("R13 final clear", v, 32'h0);

      repeat (3) @(negedge clk);
      check("R4/R6/R7 queue drained", exp_q.size(), 32'h0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule